// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This controller-side block frees an I2C bus that a target is still holding after the controller was reset partway through a read. A single trigger starts a fixed recovery routine. First, SCL is held low for a long time so that any target with a bus timeout abandons its transfer. Next, the block clocks SCL a limited number of times with SDA left floating, so the target sees a NACK at its next byte boundary. After each high phase the block looks at SDA and stops clocking as soon as the line has been let go. Because a NACK alone may not be enough, every run finishes with a real STOP condition. The block then reads both lines back and reports either success or failure.

Both line outputs are open-drain pull enables: a 1 pulls the wire low, and a 0 leaves it to the pull-up. The block never drives a line high. The line inputs are the wire levels seen at the pads. They pass through a synchronizer before the block uses them. All timing is counted in system clock cycles. The hold length, the SCL half-period, the pulse limit, the synchronizer depth and the early-exit option are all parameters. The defaults give a 50 ms hold and 5 µs half-periods at 125 MHz, with up to 12 pulses.

Top module: `bus_unjam_seq`

## Requirements
- R1: While reset is asserted, and whenever no sequence is running, `scl_pull`, `sda_pull`, `done` and `failed` are all 0. An asynchronous reset in the middle of a sequence returns all four to 0 at once.
- R2: A trigger sampled while idle makes `scl_pull` rise on the next clock edge. It then stays 1 for exactly HOLD_CYCLES + HALF_CYCLES consecutive cycles: the hold phase plus the low half of the first pulse.
- R3: `sda_pull` stays 0 through the hold phase and through every clock pulse. It first rises only after the last pulse's high phase has ended.
- R4: Each pulse releases SCL (`scl_pull` = 0) for HALF_CYCLES cycles and pulls it for HALF_CYCLES cycles. The number of pulses never exceeds PULSES.
- R5: With early exit enabled, the synchronized SDA level is sampled on the last cycle of each SCL high phase. If it is high, pulsing stops after that pulse. A target that lets SDA go during the k-th high phase therefore gets exactly k pulses (at least 1, at most PULSES).
- R6: STOP order has three steps. SCL is pulled for HALF_CYCLES cycles with SDA still released. Then SDA is pulled for 2·HALF_CYCLES cycles. SDA rises only while SCL has been pulled for at least one cycle. SCL is released HALF_CYCLES cycles before SDA. SDA falls only while SCL is released.
- R7: HALF_CYCLES cycles after SDA is released, the block samples both synchronized lines. It pulses `done` for one cycle if both are high, and otherwise pulses `failed` for one cycle. The two are never 1 together.
- R8: A trigger that arrives while a sequence is running has no effect. The running sequence keeps its timing and pulse count, and no new sequence starts after the report.
- R9: If SDA is never released, the block issues exactly PULSES pulses, then the STOP, and reports `failed`. If SCL is held low by another device, the block still finishes its routine and reports `failed`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Trigger for a recovery sequence, sampled when idle |
| scl_in | input | 1 | Level of the SCL wire |
| sda_in | input | 1 | Level of the SDA wire |
| scl_pull | output | 1 | Open-drain enable: 1 pulls SCL low |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| done | output | 1 | One-cycle pulse: both lines read high after the STOP |
| failed | output | 1 | One-cycle pulse: a line still read low after the STOP |

## Verification
The bench builds the block with HOLD_CYCLES = 40, HALF_CYCLES = 4, PULSES = 12, a two-stage synchronizer and early exit enabled. The short hold makes the length of the SCL-low run exactly countable without scaling down the pulse limit. Keeping the full pulse count of 12 puts both the cap and the never-released failure path within reach. A simple target model on the wires releases SDA after a chosen number of SCL rises, which sweeps the early exit from the first pulse up to the last. A second target model holds SCL low, which drives the failure report through the stuck-clock path.

// File: rtl/unjam_pkg.sv
package unjam_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_LOW,
      ST_HIGH,
      ST_PREP,
      ST_SDA_DOWN,
      ST_SCL_UP,
      ST_SETTLE
   } unjam_state_e;

   // SCL is pulled in the hold phase, in every low half-period and
   // through the first two steps of the STOP.
   function automatic logic scl_pulled(unjam_state_e s);
      return (s == ST_HOLD) || (s == ST_LOW) || (s == ST_PREP) ||
             (s == ST_SDA_DOWN);
   endfunction

   // SDA is pulled only inside the STOP construction.
   function automatic logic sda_pulled(unjam_state_e s);
      return (s == ST_SDA_DOWN) || (s == ST_SCL_UP);
   endfunction

endpackage

// File: rtl/unjam_sync.sv
module unjam_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] ff;

   // Lines idle high on an I2C bus, so every stage resets to 1.
   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[i] <= 1'b1;
            else        ff[i] <= d;
         end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff[i] <= 1'b1;
            else        ff[i] <= ff[i-1];
         end
      end
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/unjam_timer.sv
module unjam_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          zero
);
   logic [TW-1:0] cnt_q;

   // One shared down-counter: a phase lasts load_val+1 cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl
   import unjam_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 6_250_000,
   parameter int unsigned HALF_CYCLES = 625,
   parameter int unsigned PULSES      = 12,
   parameter bit          EARLY_EXIT  = 1'b1,
   parameter int unsigned TW          = 23,
   parameter int unsigned PW          = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          tmr_zero,
   input  logic          scl_s,
   input  logic          sda_s,
   output logic          tmr_load,
   output logic [TW-1:0] tmr_val,
   output logic          scl_pull,
   output logic          sda_pull,
   output logic          done,
   output logic          failed
);
   localparam logic [TW-1:0] HOLD_LD = TW'(HOLD_CYCLES - 1);
   localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYCLES - 1);
   localparam logic [PW-1:0] P_LAST  = PW'(PULSES - 1);
   localparam logic [PW-1:0] P_MAX   = PW'(PULSES);

   unjam_state_e st_q, nxt;
   logic [PW-1:0] pc_q;
   logic          pc_clr, pc_inc, rpt, freed;
   logic          scl_q, sda_q, done_q, fail_q;

   // Variant choice: stop clocking on a freed SDA, or always run the full count.
   if (EARLY_EXIT) begin : g_early
      assign freed = sda_s;
   end else begin : g_full
      assign freed = 1'b0;
   end

   always_comb begin
      nxt      = st_q;
      tmr_load = 1'b0;
      tmr_val  = HALF_LD;
      pc_clr   = 1'b0;
      pc_inc   = 1'b0;
      rpt      = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               nxt      = ST_HOLD;
               tmr_load = 1'b1;
               tmr_val  = HOLD_LD;
               pc_clr   = 1'b1;
            end
         end
         ST_HOLD: begin
            if (tmr_zero) begin
               nxt      = ST_LOW;
               tmr_load = 1'b1;
            end
         end
         ST_LOW: begin
            if (tmr_zero) begin
               nxt      = ST_HIGH;
               tmr_load = 1'b1;
            end
         end
         ST_HIGH: begin
            if (tmr_zero) begin
               pc_inc   = 1'b1;
               tmr_load = 1'b1;
               nxt      = ((pc_q == P_LAST) || freed) ? ST_PREP : ST_LOW;
            end
         end
         ST_PREP: begin
            if (tmr_zero) begin
               nxt      = ST_SDA_DOWN;
               tmr_load = 1'b1;
            end
         end
         ST_SDA_DOWN: begin
            if (tmr_zero) begin
               nxt      = ST_SCL_UP;
               tmr_load = 1'b1;
            end
         end
         ST_SCL_UP: begin
            if (tmr_zero) begin
               nxt      = ST_SETTLE;
               tmr_load = 1'b1;
            end
         end
         ST_SETTLE: begin
            if (tmr_zero) begin
               nxt = ST_IDLE;
               rpt = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   // Outputs come from flops loaded with the next state's decode: no glitches on the wires.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pc_q   <= '0;
         scl_q  <= 1'b0;
         sda_q  <= 1'b0;
         done_q <= 1'b0;
         fail_q <= 1'b0;
      end else begin
         st_q   <= nxt;
         scl_q  <= scl_pulled(nxt);
         sda_q  <= sda_pulled(nxt);
         done_q <= rpt &&  (scl_s && sda_s);
         fail_q <= rpt && !(scl_s && sda_s);
         if (pc_clr)      pc_q <= '0;
         else if (pc_inc) pc_q <= pc_q + 1'b1;
      end
   end

   assign scl_pull = scl_q;
   assign sda_pull = sda_q;
   assign done     = done_q;
   assign failed   = fail_q;

   AST_PULSE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q <= P_MAX); // R4
   AST_SDA_FREE_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD || st_q == ST_LOW || st_q == ST_HIGH) |-> !sda_pull); // R3
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && st_q != ST_HOLD) |=> (st_q != ST_HOLD)); // R8
   AST_REPORT_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || failed) |-> $past(st_q) == ST_SETTLE); // R7
endmodule

// File: rtl/bus_unjam_seq.sv
module bus_unjam_seq #(
   parameter int unsigned HOLD_CYCLES = 6_250_000,
   parameter int unsigned HALF_CYCLES = 625,
   parameter int unsigned PULSES      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EARLY_EXIT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_pull,
   output logic sda_pull,
   output logic done,
   output logic failed
);
   localparam int unsigned T_MAX = (HOLD_CYCLES > HALF_CYCLES) ? HOLD_CYCLES : HALF_CYCLES;
   localparam int unsigned TW    = $clog2(T_MAX + 1);
   localparam int unsigned PW    = $clog2(PULSES + 1);

   // Elaboration checks on the parameter set.
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (HALF_CYCLES <= SYNC_STAGES + 1) begin : g_chk_half
      $error("HALF_CYCLES must exceed the synchronizer latency");
   end
   if (PULSES < 1) begin : g_chk_pulses
      $error("PULSES must be at least 1");
   end
   if (HOLD_CYCLES < HALF_CYCLES) begin : g_chk_hold
      $error("HOLD_CYCLES must be no shorter than HALF_CYCLES");
   end

   logic          scl_s, sda_s, tmr_load, tmr_zero;
   logic [TW-1:0] tmr_val;

   unjam_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
   unjam_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

   unjam_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

   unjam_ctrl #(
      .HOLD_CYCLES(HOLD_CYCLES), .HALF_CYCLES(HALF_CYCLES), .PULSES(PULSES),
      .EARLY_EXIT(EARLY_EXIT), .TW(TW), .PW(PW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
      .scl_s(scl_s), .sda_s(sda_s), .tmr_load(tmr_load), .tmr_val(tmr_val),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .done(done), .failed(failed));

   AST_SDA_DOWN_UNDER_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> (scl_pull && $past(scl_pull))); // R6
   AST_SDA_UP_WITH_SCL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_pull) |-> !scl_pull); // R6
   AST_REPORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && failed)); // R7
   AST_REPORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || failed) |=> !(done || failed)); // R7
   AST_REPORT_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (done || failed) |-> (!scl_pull && !sda_pull)); // R1
endmodule

// File: tb/bus_unjam_seq_tb_top.sv
module bus_unjam_seq_tb_top;
   localparam int HOLD   = 40;
   localparam int HALF   = 4;
   localparam int NPULSE = 12;

   // Vector fields: [17:10] SCL rises before target frees SDA, [9] target holds SCL,
   // [8:1] expected pulses, [0] expected failed.
   localparam int NVEC = 7;
   localparam logic [17:0] VEC [NVEC] = '{
      {8'd0,  1'b0, 8'd1,  1'b0},
      {8'd1,  1'b0, 8'd1,  1'b0},
      {8'd3,  1'b0, 8'd3,  1'b0},
      {8'd5,  1'b0, 8'd5,  1'b0},
      {8'd12, 1'b0, 8'd12, 1'b0},
      {8'd20, 1'b0, 8'd12, 1'b1},
      {8'd0,  1'b1, 8'd1,  1'b1}
   };

   logic clk = 1'b0;
   logic rst_n, start;
   logic tgt_scl_low, tgt_sda_low;
   logic scl_line, sda_line;
   logic scl_pull, sda_pull, done, failed;
   int   total = 0, bad = 0, cyc = 0;

   always #4 clk = ~clk;

   assign scl_line = !scl_pull && !tgt_scl_low;
   assign sda_line = !sda_pull && !tgt_sda_low;

   bus_unjam_seq #(
      .HOLD_CYCLES(HOLD), .HALF_CYCLES(HALF), .PULSES(NPULSE),
      .SYNC_STAGES(2), .EARLY_EXIT(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .scl_in(scl_line), .sda_in(sda_line),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .done(done), .failed(failed));

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check_eq(string req, string what, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic run_seq(int k, bit stuck, int exp_p, bit exp_f, bit poke);
      int  it = 0, rises = 0, rel = 0, first_run = 0, sda_cnt = 0, rel_at_sda = -1;
      bit  in_first = 1, fin = 0, rise_ok = 0, fall_ok = 0, got_done = 0, got_fail = 0;
      bit  both = 0;
      logic prev_scl, prev_sda, prev_line;
      @(negedge clk);
      tgt_scl_low = stuck;
      tgt_sda_low = (k > 0);
      start = 1'b1;
      prev_scl = scl_pull;
      prev_sda = sda_pull;
      prev_line = scl_line;
      while (!fin && it < 4000) begin
         @(negedge clk);
         it++;
         start = (poke && (it == 10 || it == 70)) ? 1'b1 : 1'b0;
         if (in_first) begin
            if (scl_pull) first_run++;
            else if (first_run > 0) in_first = 0;
         end
         if (prev_scl && !scl_pull) rel++;
         if (scl_line && !prev_line) rises++;
         tgt_sda_low = (rises < k);
         if (sda_pull) sda_cnt++;
         if (sda_pull && !prev_sda) begin
            rel_at_sda = rel;
            rise_ok = scl_pull && prev_scl;
         end
         if (!sda_pull && prev_sda) fall_ok = !scl_pull;
         if (done || failed) begin
            fin = 1;
            got_done = done;
            got_fail = failed;
            both = done && failed;
         end
         prev_scl = scl_pull;
         prev_sda = sda_pull;
         prev_line = scl_line;
      end
      start = 1'b0;
      check_eq("R2", "SCL low run length", first_run, HOLD + HALF);
      check_eq("R5", "pulses issued", rel - 1, exp_p);
      check_eq("R3", "pulses before SDA pulled", rel_at_sda, exp_p);
      check_eq("R6", "SDA pulled cycles", sda_cnt, 2 * HALF);
      check_eq("R6", "SDA pulled under pulled SCL", int'(rise_ok), 1);
      check_eq("R6", "SDA released with SCL free", int'(fall_ok), 1);
      check_eq("R7", "failed reported", int'(got_fail), int'(exp_f));
      check_eq("R7", "done reported", int'(got_done), int'(!exp_f));
      check_eq("R7", "done and failed together", int'(both), 0);
      @(negedge clk);
      check_eq("R7", "report width", int'(done || failed), 0);
      if (poke) begin
         int pulled = 0;
         for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (scl_pull || sda_pull) pulled++;
         end
         check_eq("R8", "restart after ignored trigger", pulled, 0);
      end
      tgt_scl_low = 1'b0;
      tgt_sda_low = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      tgt_scl_low = 1'b0;
      tgt_sda_low = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check_eq("R1", "outputs in reset", int'({scl_pull, sda_pull, done, failed}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1", "outputs idle", int'({scl_pull, sda_pull, done, failed}), 0);

      // Table walk: R2 R3 R4 R5 R6 R7 R9
      for (int v = 0; v < NVEC; v++) begin
         run_seq(int'(VEC[v][17:10]), VEC[v][9], int'(VEC[v][8:1]), VEC[v][0], 1'b0);
      end

      // R9: never-released SDA gives the full pulse count and failed (vector 5);
      // R4: the cap of 12 is reached there and in vector 4.
      // R8: triggers during the hold and during the pulses are ignored.
      run_seq(12, 1'b0, 12, 1'b0, 1'b1);

      // R1: reset in the middle of pulsing drops every output at once.
      @(negedge clk);
      tgt_sda_low = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (60) @(negedge clk);
      check_eq("R1", "SDA not yet pulled mid-run", int'(sda_pull), 0);
      rst_n = 1'b0;
      #1;
      check_eq("R1", "outputs after mid-run reset", int'({scl_pull, sda_pull, done, failed}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      tgt_sda_low = 1'b0;
      repeat (5) @(negedge clk);
      check_eq("R1", "idle after reset release", int'({scl_pull, sda_pull, done, failed}), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule